// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory request into the per-element addresses a banked memory port needs. A request names a base byte address, an addressing mode, a signed stride, an element size and a vector length. The block hands out the elements in groups, one group per lane count (`LANES`) of elements. For each lane it gives a byte address, a set of enables at the memory's minimum access granularity, and a misalignment flag. Three modes are served: consecutive elements, elements spaced by a signed stride, and elements placed by a per-element signed offset that the caller streams in.

Every request follows a fixed schedule. There is one setup cycle, then two cycles for each group, then one drain cycle. A load of `G` groups therefore keeps the block busy for `2*G+2` cycles. In indexed mode the block requests the offsets for the next group one cycle before it presents that group. The data crossbar and the memory are outside the block.

Top module: `vag_addr_gen`

## Requirements
- R1: After reset `busy`, `grp_vld`, `done` and `off_req` are all low.
- R2: A `start` seen while idle makes `busy` high for exactly `2*G+2` cycles, where `G = ceil(VL/LANES)`. Group `g` (counting from 0) is presented with `grp_vld` high in busy cycle `2+2g`, counting from 1. `grp_vld` is low in all other cycles. `done` is high only in the last busy cycle.
- R3: Mode code 0 (unit): element `e` has address `base + e*B`, where `B` is the element size in bytes. Element size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R4: Mode code 1 (strided): element `e` has address `base + e*stride*B`, where `stride` is a signed two's-complement element count. Addresses wrap modulo 2^ADDR_W.
- R5: Mode codes 2 and 3 (indexed): element `e` has address `base + off[e]*B`, where `off` is signed. `off_req` is high in the cycle before each group is presented, and only in indexed mode. The offsets for lane `l` of that group are read from `offs[l*OFF_W +: OFF_W]` at the end of that cycle.
- R6: In a presented group, lane `l` carries element `g*LANES+l`. Its `lane_vld` bit is high only when that element index is below VL. `lane_vld` is all zero when `grp_vld` is low.
- R7: Enable bit `k` of a lane covers the `GRAN_BYTES` bytes starting at `k*GRAN_BYTES` within the `WORD_BYTES`-wide word. An aligned element sets the bits from `addr_lo/GRAN_BYTES` onward. The count of bits set is `max(B/GRAN_BYTES, 1)`. Invalid lanes have all enables low.
- R8: A valid lane whose address is not a multiple of `B` is misaligned, and so is any lane when the element size code is 3. A misaligned lane has all enables low. `grp_err` is high exactly when some valid lane of the group is misaligned.
- R9: `start` is ignored while `busy` is high. The running request's addresses, timing and length are unchanged.
- R10: VL = 0 gives two busy cycles, no group and no `off_req`.
- R11: A VL above `MAXVL` is treated as `MAXVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 2 | 0 unit, 1 strided, 2/3 indexed |
| base | input | ADDR_W | Base byte address |
| stride | input | STRIDE_W | Signed stride in elements |
| esize | input | 2 | Element size code |
| vl | input | VL_W | Vector length in elements |
| offs | input | LANES*OFF_W | Signed per-lane offsets for the next group |
| busy | output | 1 | Request in progress |
| off_req | output | 1 | Offsets for the next group are sampled this cycle |
| grp_vld | output | 1 | A group of addresses is presented |
| lane_vld | output | LANES | Per-lane element valid |
| grp_addr | output | LANES*ADDR_W | Per-lane byte addresses |
| grp_be | output | LANES*BE_W | Per-lane enables at access granularity |
| grp_err | output | 1 | Some valid lane is misaligned |
| done | output | 1 | Last cycle of the request |

## Verification
The bench aims at the schedule edges. With VL = 0, a design that always emits a group would show a stray `grp_vld`. With VL not a multiple of the lane count, a wrong final-group mask would present addresses past the vector end. The bench uses negative strides and negative offsets, which catch a zero-extending adder by producing addresses far above the base. It also checks sub-word elements at every byte position and misaligned half-words, so a shifted or unsuppressed enable shows up on the wrong bytes. Finally, it raises `start` mid-request and asks for a VL above the maximum. A design that restarts on that `start` would shorten the request and change its addresses. A design that does not clamp VL would run extra groups.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DATA  = 3'd3,
        PH_DRAIN = 3'd4
    } phase_t;

    localparam logic [1:0] MODE_UNIT   = 2'd0;
    localparam logic [1:0] MODE_STRIDE = 2'd1;

    localparam logic [1:0] ESZ_BAD = 2'd3;

endpackage

// File: rtl/vag_be.sv
module vag_be #(
    parameter int WORD_BYTES = 4,
    parameter int GRAN_BYTES = 1,
    localparam int LO_W = $clog2(WORD_BYTES),
    localparam int BE_W = WORD_BYTES / GRAN_BYTES
) (
    input  logic [LO_W-1:0] lo,
    input  logic [1:0]      esize,
    output logic [BE_W-1:0] be,
    output logic            err
);
    import vag_pkg::*;

    always_comb begin
        int eb;
        int lo_i;
        int first;
        int cnt;
        eb    = 1 << esize;
        lo_i  = int'(lo);
        err   = (esize == ESZ_BAD) || ((lo_i % eb) != 0);
        first = lo_i / GRAN_BYTES;
        cnt   = (eb >= GRAN_BYTES) ? (eb / GRAN_BYTES) : 1;
        for (int k = 0; k < BE_W; k++) begin
            be[k] = !err && (k >= first) && (k < first + cnt);
        end
    end

endmodule

// File: rtl/vag_lane.sv
module vag_lane #(
    parameter int ADDR_W     = 32,
    parameter int ACC_W      = 24,
    parameter int OFF_W      = 16,
    parameter int WORD_BYTES = 4,
    parameter int GRAN_BYTES = 1,
    localparam int LO_W = $clog2(WORD_BYTES),
    localparam int BE_W = WORD_BYTES / GRAN_BYTES
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ACC_W-1:0]  step_idx,
    input  logic [OFF_W-1:0]  off,
    input  logic              use_off,
    input  logic [1:0]        esize,
    output logic [ADDR_W-1:0] addr,
    output logic [BE_W-1:0]   be,
    output logic              err
);
    logic [ADDR_W-1:0] idx_ext;

    // signed element index, widened to the address width
    always_comb begin
        if (use_off) begin
            idx_ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
        end else begin
            idx_ext = {{(ADDR_W-ACC_W){step_idx[ACC_W-1]}}, step_idx};
        end
        addr = base + (idx_ext << esize);
    end

    vag_be #(
        .WORD_BYTES(WORD_BYTES),
        .GRAN_BYTES(GRAN_BYTES)
    ) u_be (
        .lo   (addr[LO_W-1:0]),
        .esize(esize),
        .be   (be),
        .err  (err)
    );

endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen #(
    parameter int LANES      = 4,
    parameter int ADDR_W     = 32,
    parameter int STRIDE_W   = 16,
    parameter int OFF_W      = 16,
    parameter int MAXVL      = 64,
    parameter int WORD_BYTES = 4,
    parameter int GRAN_BYTES = 1,
    localparam int VL_W    = $clog2(MAXVL + 1),
    localparam int EI_W    = VL_W + 1,
    localparam int ACC_W   = STRIDE_W + VL_W + 1,
    localparam int BE_W    = WORD_BYTES / GRAN_BYTES,
    localparam int LANE_SH = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              mode,
    input  logic [ADDR_W-1:0]       base,
    input  logic [STRIDE_W-1:0]     stride,
    input  logic [1:0]              esize,
    input  logic [VL_W-1:0]         vl,
    input  logic [LANES*OFF_W-1:0]  offs,
    output logic                    busy,
    output logic                    off_req,
    output logic                    grp_vld,
    output logic [LANES-1:0]        lane_vld,
    output logic [LANES*ADDR_W-1:0] grp_addr,
    output logic [LANES*BE_W-1:0]   grp_be,
    output logic                    grp_err,
    output logic                    done
);
    import vag_pkg::*;

    typedef struct packed {
        phase_t                         phase;
        logic [VL_W-1:0]                left;
        logic [VL_W-1:0]                vl;
        logic [EI_W-1:0]                eidx;
        logic [ACC_W-1:0]               acc;
        logic [ACC_W-1:0]               stride;
        logic [ADDR_W-1:0]              base;
        logic [1:0]                     esize;
        logic                           use_off;
        logic [LANES-1:0]               vld;
        logic [LANES-1:0][ADDR_W-1:0]   addr;
        logic [LANES-1:0][BE_W-1:0]     be;
        logic                           err;
    } st_t;

    st_t st_d, st_q;

    logic [LANES-1:0][ADDR_W-1:0] ln_addr;
    logic [LANES-1:0][BE_W-1:0]   ln_be;
    logic [LANES-1:0]             ln_err;
    logic [LANES-1:0]             ln_vld;
    logic [VL_W-1:0]              vl_cl;
    logic [EI_W-1:0]              grp_cnt;
    logic [ACC_W-1:0]             stride_ext;
    logic [ACC_W-1:0]             grp_step;

    assign vl_cl      = (vl > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl;
    assign grp_cnt    = ({1'b0, vl_cl} + EI_W'(LANES - 1)) >> LANE_SH;
    assign stride_ext = {{(ACC_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};
    assign grp_step   = st_q.stride * ACC_W'(LANES);

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        logic [ACC_W-1:0] step_idx;
        assign step_idx    = st_q.acc + st_q.stride * ACC_W'(gl);
        assign ln_vld[gl]  = (st_q.eidx + EI_W'(gl)) < {1'b0, st_q.vl};

        vag_lane #(
            .ADDR_W    (ADDR_W),
            .ACC_W     (ACC_W),
            .OFF_W     (OFF_W),
            .WORD_BYTES(WORD_BYTES),
            .GRAN_BYTES(GRAN_BYTES)
        ) u_lane (
            .base    (st_q.base),
            .step_idx(step_idx),
            .off     (offs[gl*OFF_W +: OFF_W]),
            .use_off (st_q.use_off),
            .esize   (st_q.esize),
            .addr    (ln_addr[gl]),
            .be      (ln_be[gl]),
            .err     (ln_err[gl])
        );

        assign grp_addr[gl*ADDR_W +: ADDR_W] = st_q.addr[gl];
        assign grp_be[gl*BE_W +: BE_W]       = st_q.be[gl];
    end

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_SETUP;
                    st_d.vl      = vl_cl;
                    st_d.left    = grp_cnt[VL_W-1:0];
                    st_d.eidx    = '0;
                    st_d.acc     = '0;
                    st_d.base    = base;
                    st_d.esize   = esize;
                    st_d.use_off = mode[1];
                    if (mode == MODE_UNIT) begin
                        st_d.stride = ACC_W'(1);
                    end else if (mode == MODE_STRIDE) begin
                        st_d.stride = stride_ext;
                    end else begin
                        st_d.stride = '0;
                    end
                end
            end
            PH_SETUP, PH_DATA: begin
                if (st_q.left == '0) begin
                    st_d.phase = PH_DRAIN;
                end else begin
                    st_d.phase = PH_ADDR;
                    st_d.left  = st_q.left - 1'b1;
                    st_d.eidx  = st_q.eidx + EI_W'(LANES);
                    st_d.acc   = st_q.acc + grp_step;
                    st_d.vld   = ln_vld;
                    st_d.addr  = ln_addr;
                    st_d.err   = |(ln_err & ln_vld);
                    for (int l = 0; l < LANES; l++) begin
                        st_d.be[l] = ln_vld[l] ? ln_be[l] : '0;
                    end
                end
            end
            PH_ADDR:  st_d.phase = PH_DATA;
            PH_DRAIN: st_d.phase = PH_IDLE;
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign grp_vld  = (st_q.phase == PH_ADDR);
    assign done     = (st_q.phase == PH_DRAIN);
    assign lane_vld = grp_vld ? st_q.vld : '0;
    assign grp_err  = grp_vld && st_q.err;
    assign off_req  = st_q.use_off && (st_q.left != '0) &&
                      ((st_q.phase == PH_SETUP) || (st_q.phase == PH_DATA));

endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
    parameter int LANES = 4,
    parameter int BE_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   off_req,
    input logic                   grp_vld,
    input logic [LANES-1:0]       lane_vld,
    input logic [LANES*BE_W-1:0]  grp_be,
    input logic                   grp_err,
    input logic                   done
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!grp_vld && !done && !off_req));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_group_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grp_vld |=> (!grp_vld && busy));

    assert_offreq_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |=> grp_vld);

    assert_lane_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_vld |-> ((lane_vld & (lane_vld + 1'b1)) == '0));

    assert_start_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
        assert_idle_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_vld && !lane_vld[gl]) |-> (grp_be[gl*BE_W +: BE_W] == '0));

        assert_clean_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_vld && !grp_err && lane_vld[gl]) |-> (grp_be[gl*BE_W +: BE_W] != '0));
    end

endmodule

bind vag_addr_gen vag_chk #(
    .LANES(LANES),
    .BE_W (BE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .off_req (off_req),
    .grp_vld (grp_vld),
    .lane_vld(lane_vld),
    .grp_be  (grp_be),
    .grp_err (grp_err),
    .done    (done)
);

// File: tb/vag_addr_gen_tb.sv
`timescale 1ns/1ps
module vag_addr_gen_tb;
    localparam int LANES = 4;
    localparam int AW    = 32;
    localparam int SW    = 16;
    localparam int OW    = 16;
    localparam int MAXVL = 64;
    localparam int VW    = $clog2(MAXVL + 1);
    localparam int GRAN  = 1;
    localparam int BEW   = 4 / GRAN;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mode = '0;
    logic [AW-1:0]     base = '0;
    logic [SW-1:0]     stride = '0;
    logic [1:0]        esize = '0;
    logic [VW-1:0]     vl = '0;
    logic [LANES*OW-1:0] offs = '0;
    logic              busy, off_req, grp_vld, grp_err, done;
    logic [LANES-1:0]  lane_vld;
    logic [LANES*AW-1:0] grp_addr;
    logic [LANES*BEW-1:0] grp_be;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int off_tab [0:MAXVL-1];

    always #4 clk = ~clk;

    vag_addr_gen #(.LANES(LANES), .ADDR_W(AW), .STRIDE_W(SW), .OFF_W(OW),
                   .MAXVL(MAXVL), .WORD_BYTES(4), .GRAN_BYTES(GRAN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
        .stride(stride), .esize(esize), .vl(vl), .offs(offs), .busy(busy),
        .off_req(off_req), .grp_vld(grp_vld), .lane_vld(lane_vld),
        .grp_addr(grp_addr), .grp_be(grp_be), .grp_err(grp_err), .done(done));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        chk(busy == 1'b0 && grp_vld == 1'b0, "R1", "busy/grp_vld", {busy, grp_vld}, 0);
        chk(done == 1'b0 && off_req == 1'b0, "R1", "done/off_req", {done, off_req}, 0);
    endtask

    // one full request; every expectation comes from the requirement text
    task automatic run_op(input logic [1:0] md, input logic [31:0] b, input int st,
                          input logic [1:0] es, input int n, input bit inj,
                          input string atag);
        int n_eff = (n > MAXVL) ? MAXVL : n;
        int grps  = (n_eff + LANES - 1) / LANES;
        int bc = 0, g = 0, done_at = -1, oreq = 0, stray = 0;
        @(negedge clk);
        start = 1'b1; mode = md; base = b; stride = st[SW-1:0]; esize = es; vl = VW'(n);
        @(negedge clk);
        start = 1'b0; base = 32'hDEAD_0000;
        while (busy && bc < 400) begin
            bc++;
            if (done) done_at = bc;
            if (grp_vld) begin
                bit any_err = 1'b0;
                chk(bc == 2 + 2 * g, "R2", "group slot", bc, 2 + 2 * g);
                for (int l = 0; l < LANES; l++) begin
                    int e = g * LANES + l;
                    bit ev = (e < n_eff);
                    chk(lane_vld[l] == ev, "R6", "lane valid", lane_vld[l], ev);
                    if (ev) begin
                        longint term;
                        logic [31:0] ea;
                        int eb = 1 << es;
                        bit eerr;
                        logic [BEW-1:0] ebe = '0;
                        if (md == 2'd0) term = e;
                        else if (md == 2'd1) term = longint'(e) * st;
                        else term = off_tab[e];
                        ea = b + 32'(term * eb);
                        eerr = (es == 2'd3) || ((ea % eb) != 0);
                        any_err |= eerr;
                        if (!eerr) begin
                            int cnt = (eb >= GRAN) ? eb / GRAN : 1;
                            for (int k = 0; k < BEW; k++)
                                ebe[k] = (k >= ea[1:0] / GRAN) && (k < ea[1:0] / GRAN + cnt);
                        end
                        if (es != 2'd3)
                            chk(grp_addr[l*AW +: AW] == ea, atag, "address",
                                grp_addr[l*AW +: AW], ea);
                        chk(grp_be[l*BEW +: BEW] == ebe, eerr ? "R8" : "R7", "enables",
                            grp_be[l*BEW +: BEW], ebe);
                    end else begin
                        chk(grp_be[l*BEW +: BEW] == '0, "R7", "idle lane enables",
                            grp_be[l*BEW +: BEW], 0);
                    end
                end
                chk(grp_err == any_err, "R8", "group error", grp_err, any_err);
                g++;
            end else if (lane_vld != '0) begin
                stray++;
            end
            if (off_req) begin
                oreq++;
                for (int l = 0; l < LANES; l++) begin
                    int e = g * LANES + l;
                    offs[l*OW +: OW] = (e < MAXVL) ? off_tab[e][OW-1:0] : '0;
                end
            end
            start = (inj && bc == 3);
            if (start) begin mode = 2'd0; vl = VW'(1); base = 32'h0; end
            @(negedge clk);
        end
        start = 1'b0;
        chk(bc == 2 * grps + 2, "R2", "busy length", bc, 2 * grps + 2);
        chk(done_at == bc, "R2", "done cycle", done_at, bc);
        chk(g == grps, (n > MAXVL) ? "R11" : (n == 0 ? "R10" : "R2"), "group count", g, grps);
        chk(oreq == (md[1] ? grps : 0), "R5", "offset requests", oreq, md[1] ? grps : 0);
        chk(stray == 0, "R6", "lane valid outside group", stray, 0);
        if (inj) chk(busy == 1'b0, "R9", "no restart after drain", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < MAXVL; i++) off_tab[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset();

        run_op(2'd0, 32'h0000_1000, 0, 2'd2, 10, 1'b0, "R3");
        run_op(2'd0, 32'h0000_0203, 0, 2'd0, 7, 1'b0, "R3");
        run_op(2'd0, 32'h0000_0102, 0, 2'd1, 5, 1'b0, "R3");
        run_op(2'd1, 32'h0000_0400, 3, 2'd1, 9, 1'b0, "R4");
        run_op(2'd1, 32'h0000_8000, -2, 2'd2, 8, 1'b0, "R4");
        run_op(2'd1, 32'h0000_0010, -5, 2'd2, 6, 1'b0, "R4");

        for (int i = 0; i < MAXVL; i++) off_tab[i] = ((i * 7) % 13) - 6;
        run_op(2'd2, 32'h0000_2000, 0, 2'd2, 6, 1'b0, "R5");
        run_op(2'd3, 32'h0000_0300, 0, 2'd0, 4, 1'b0, "R5");

        run_op(2'd0, 32'h0000_0101, 0, 2'd1, 4, 1'b0, "R8");
        run_op(2'd0, 32'h0000_0100, 0, 2'd3, 2, 1'b0, "R8");

        run_op(2'd1, 32'h0000_0040, 1, 2'd0, 0, 1'b0, "R10");
        run_op(2'd0, 32'h0000_4000, 0, 2'd2, 100, 1'b0, "R11");
        run_op(2'd1, 32'h0000_0600, 2, 2'd1, 12, 1'b1, "R9");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule